// File: doc/BRIEF.md
# Byte-Window Program RAM Loader

This block lets a host fill the program store of an embedded sequencer with 32-bit instruction words. The host only has a byte-wide register port. A word is sent as four byte writes to one data window. The block gathers the bytes, least significant first. When the fourth byte arrives, it writes the whole word to a 512 x 32 synchronous RAM in that same cycle.

The word address is 9 bits wide and sits in two host registers. The low register holds address bits 7..0. Bit 0 of the high register holds address bit 8. The address moves to the next word only after the most significant byte of a word has been written or read, and it wraps from 511 to 0. Reads of the data window step through the bytes of the stored word in the same order as writes do.

A control register has two bits. One enables loading; data-window writes are dropped while it is clear. The other drives a reset line that holds the sequencer core in reset.

Top module: `prog_ram_loader`

## Requirements
- R1: After reset, the control register reads 0, both address registers read 0, `seq_reset` is low, no RAM write occurs, and the byte index is 0.
- R2: Control bit 0 is the load enable and control bit 1 drives `seq_reset`. Both bits read back at the same positions, and the other bits read 0.
- R3: Register select codes are: 0 control, 1 data window, 2 address low, 3 address high. Four data-window writes are taken least significant byte first. The fourth write raises `ram_we` in that same cycle, with `ram_addr` set to the current word address and `ram_wdata` set to the assembled word.
- R4: The first, second and third byte writes of a word leave the word address unchanged. The address moves up by one in the clock edge that commits the fourth byte.
- R5: The address low register holds address bits 7..0. Bit 0 of the address high register holds address bit 8. Bits 7..1 of the high register read as 0, whatever value was written to them.
- R6: A write to either address register sets the byte index back to 0, so the next data-window byte becomes byte 0 of a new word.
- R7: While the load enable is clear, data-window writes cause no RAM write, do not advance the byte index and do not change the address. A word that is partly assembled continues once loading is enabled again.
- R8: Reads of the data window return the bytes of the word at the current address, least significant first. The address moves up by one after the fourth read.
- R9: The word address wraps from 511 to 0, after a write and after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_sel | input | 2 | Host register select: 0 control, 1 data window, 2 address low, 3 address high |
| reg_wr | input | 1 | Host write strobe, one access per cycle |
| reg_rd | input | 1 | Host read strobe; ignored while `reg_wr` is high |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for the selected register, valid in the cycle of the access |
| seq_reset | output | 1 | Reset to the sequencer core, taken from control bit 1 |
| ram_we | output | 1 | Program RAM write enable, one cycle per committed word |
| ram_addr | output | 9 | Program RAM word address, used for both read and write |
| ram_wdata | output | 32 | Assembled instruction word |
| ram_rdata | input | 32 | RAM read data for the address presented one cycle earlier |

## Verification
A wrong byte index shows up on the RAM port at the next commit, as bytes in the wrong lanes. It also shows on `reg_rdata` at the next data-window read. An address that is off by one, or that advances too early, is visible right away: the bench reads the address registers back after every byte. A load-enable fault shows as an extra `ram_we` pulse, or a missing one, on the fourth byte of the word that is affected.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

  // Host register select codes; the bench and the checker rely on these.
  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_DATA    = 2'd1,
    SEL_ADDR_LO = 2'd2,
    SEL_ADDR_HI = 2'd3
  } ldr_sel_e;

  // Control register bit positions.
  localparam int unsigned CTRL_LOAD_BIT   = 0;
  localparam int unsigned CTRL_SEQRST_BIT = 1;

endpackage

// File: rtl/ldr_ctrl_reg.sv
module ldr_ctrl_reg #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic              load_en,
  output logic              seq_reset,
  output logic [BYTE_W-1:0] rd_value
);
  import ldr_pkg::*;

  logic load_en_d;
  logic seq_reset_d;

  always_comb begin
    load_en_d   = load_en;
    seq_reset_d = seq_reset;
    if (wr_en) begin
      load_en_d   = wdata[CTRL_LOAD_BIT];
      seq_reset_d = wdata[CTRL_SEQRST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_en   <= 1'b0;
      seq_reset <= 1'b0;
    end else begin
      load_en   <= load_en_d;
      seq_reset <= seq_reset_d;
    end
  end

  always_comb begin
    rd_value                  = '0;
    rd_value[CTRL_LOAD_BIT]   = load_en;
    rd_value[CTRL_SEQRST_BIT] = seq_reset;
  end

endmodule

// File: rtl/ldr_addr_reg.sv
module ldr_addr_reg #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] rd_lo,
  output logic [BYTE_W-1:0] rd_hi
);
  localparam int unsigned HI_W = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  // Host writes and auto-advance never coincide: one access per cycle.
  always_comb begin
    addr_d  = addr;
    addr_en = 1'b0;
    if (wr_lo) begin
      addr_d[BYTE_W-1:0] = wdata;
      addr_en            = 1'b1;
    end else if (wr_hi) begin
      addr_d[ADDR_W-1:BYTE_W] = wdata[HI_W-1:0];
      addr_en                 = 1'b1;
    end else if (advance) begin
      addr_d  = addr + 1'b1;
      addr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (addr_en) begin
      addr <= addr_d;
    end
  end

  always_comb begin
    rd_lo = addr[BYTE_W-1:0];
    rd_hi = '0;
    rd_hi[HI_W-1:0] = addr[ADDR_W-1:BYTE_W];
  end

endmodule

// File: rtl/ldr_byte_seq.sv
module ldr_byte_seq #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned IDX_W     = $clog2(WORD_BYTES),
  localparam int unsigned HOLD_W    = BYTE_W * (WORD_BYTES - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_wr,
  input  logic              step_rd,
  input  logic              clear,
  input  logic [BYTE_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx,
  output logic              last_byte,
  output logic [HOLD_W-1:0] hold
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

  logic [IDX_W-1:0] idx_d;
  logic             step;

  assign step      = step_wr | step_rd;
  assign last_byte = (idx == LAST_IDX);

  always_comb begin
    idx_d = idx;
    if (clear) begin
      idx_d = '0;
    end else if (step) begin
      idx_d = last_byte ? '0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else begin
      idx <= idx_d;
    end
  end

  // One holding lane per byte below the top one; the top byte goes straight to RAM.
  for (genvar g = 0; g < WORD_BYTES - 1; g++) begin : g_lane
    logic lane_en;
    assign lane_en = step_wr && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold[g*BYTE_W +: BYTE_W] <= '0;
      end else if (lane_en) begin
        hold[g*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  end

endmodule

// File: rtl/prog_ram_loader.sv
module prog_ram_loader #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned WORD_W    = BYTE_W * WORD_BYTES,
  localparam int unsigned IDX_W     = $clog2(WORD_BYTES),
  localparam int unsigned HOLD_W    = BYTE_W * (WORD_BYTES - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              seq_reset,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [WORD_W-1:0] ram_wdata,
  input  logic [WORD_W-1:0] ram_rdata
);
  import ldr_pkg::*;

  ldr_sel_e          sel;
  logic              host_rd;
  logic              ctrl_wr;
  logic              lo_wr;
  logic              hi_wr;
  logic              data_wr;
  logic              data_rd;
  logic              load_en;
  logic [IDX_W-1:0]  byte_idx;
  logic              last_byte;
  logic [HOLD_W-1:0] hold;
  logic              advance;
  logic [BYTE_W-1:0] ctrl_rd_value;
  logic [BYTE_W-1:0] lo_rd_value;
  logic [BYTE_W-1:0] hi_rd_value;
  logic [BYTE_W-1:0] data_rd_value;

  // Access decode; a write takes precedence over a read in the same cycle.
  assign sel     = ldr_sel_e'(reg_sel);
  assign host_rd = reg_rd & ~reg_wr;
  assign ctrl_wr = reg_wr && (sel == SEL_CTRL);
  assign lo_wr   = reg_wr && (sel == SEL_ADDR_LO);
  assign hi_wr   = reg_wr && (sel == SEL_ADDR_HI);
  assign data_wr = reg_wr && (sel == SEL_DATA) && load_en;
  assign data_rd = host_rd && (sel == SEL_DATA);

  ldr_ctrl_reg #(
    .BYTE_W (BYTE_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_wr),
    .wdata     (reg_wdata),
    .load_en   (load_en),
    .seq_reset (seq_reset),
    .rd_value  (ctrl_rd_value)
  );

  ldr_byte_seq #(
    .BYTE_W     (BYTE_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_bseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_wr   (data_wr),
    .step_rd   (data_rd),
    .clear     (lo_wr | hi_wr),
    .wdata     (reg_wdata),
    .idx       (byte_idx),
    .last_byte (last_byte),
    .hold      (hold)
  );

  assign advance = (data_wr | data_rd) & last_byte;

  ldr_addr_reg #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (lo_wr),
    .wr_hi   (hi_wr),
    .wdata   (reg_wdata),
    .advance (advance),
    .addr    (ram_addr),
    .rd_lo   (lo_rd_value),
    .rd_hi   (hi_rd_value)
  );

  // Commit in the cycle of the top byte: held lanes plus the byte on the bus.
  assign ram_we    = data_wr & last_byte;
  assign ram_wdata = {reg_wdata, hold};

  // The RAM read port follows ram_addr; pick the lane for the current byte.
  assign data_rd_value = ram_rdata[byte_idx*BYTE_W +: BYTE_W];

  always_comb begin
    unique case (sel)
      SEL_CTRL:    reg_rdata = ctrl_rd_value;
      SEL_DATA:    reg_rdata = data_rd_value;
      SEL_ADDR_LO: reg_rdata = lo_rd_value;
      SEL_ADDR_HI: reg_rdata = hi_rd_value;
      default:     reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ldr_checker.sv
module ldr_checker #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned IDX_W      = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_sel,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic [BYTE_W-1:0] reg_rdata,
  input logic              seq_reset,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              load_en,
  input logic [IDX_W-1:0]  byte_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

  assert_seqrst_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0) |=> (seq_reset == $past(reg_wdata[1])));

  assert_commit_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (ram_addr == ADDR_W'($past(ram_addr) + 1'b1)));

  assert_partial_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1 && !ram_we) |=> $stable(ram_addr));

  assert_hi_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd3) |-> ((reg_rdata >> (ADDR_W - BYTE_W)) == '0));

  assert_idx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel[1]) |=> (byte_idx == '0));

  assert_we_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (reg_wr && reg_sel == 2'd1 && load_en));

  assert_read_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_sel == 2'd1 && byte_idx == LAST_IDX)
      |=> (ram_addr == ADDR_W'($past(ram_addr) + 1'b1)));

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_addr == '1) |=> (ram_addr == '0));

endmodule

bind prog_ram_loader ldr_checker #(
  .ADDR_W     (ADDR_W),
  .BYTE_W     (BYTE_W),
  .WORD_BYTES (WORD_BYTES),
  .IDX_W      (IDX_W)
) u_chk (.*);

// File: tb/prog_ram_loader_bench.sv
`timescale 1ns/1ps
module prog_ram_loader_bench;

  logic        clk;
  logic        rst_n;
  logic [1:0]  reg_sel;
  logic        reg_wr;
  logic        reg_rd;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        seq_reset;
  logic        ram_we;
  logic [8:0]  ram_addr;
  logic [31:0] ram_wdata;
  logic [31:0] ram_rdata;

  int checks;
  int failures;
  bit done;

  int          we_cnt;
  logic [8:0]  last_waddr;
  logic [31:0] last_wdata;
  logic [31:0] mem [0:511];

  prog_ram_loader u_prog_ram_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .seq_reset (seq_reset),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Synchronous program RAM model, read-before-write.
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  // Observe commits on the RAM port.
  always @(posedge clk) begin
    if (!rst_n) begin
      we_cnt <= 0;
    end else if (ram_we) begin
      we_cnt     <= we_cnt + 1;
      last_waddr <= ram_addr;
      last_wdata <= ram_wdata;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] sel, output logic [7:0] data);
    @(negedge clk);
    reg_sel = sel; reg_rd = 1'b1;
    #1 data = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_addr(input logic [8:0] a);
    host_write(2'd2, a[7:0]);
    host_write(2'd3, {7'd0, a[8]});
  endtask

  task automatic read_addr(output logic [8:0] a);
    logic [7:0] lo;
    logic [7:0] hi;
    host_read(2'd2, lo);
    host_read(2'd3, hi);
    a = {hi[0], lo};
  endtask

  task automatic t_reset;
    logic [7:0] v;
    host_read(2'd0, v); check("R1 ctrl", {24'd0, v}, 32'h0);
    host_read(2'd2, v); check("R1 addr lo", {24'd0, v}, 32'h0);
    host_read(2'd3, v); check("R1 addr hi", {24'd0, v}, 32'h0);
    check("R1 seq_reset", {31'd0, seq_reset}, 32'h0);
    check("R1 no write", we_cnt, 0);
  endtask

  task automatic t_ctrl;
    logic [7:0] v;
    host_write(2'd0, 8'hFF);
    host_read(2'd0, v); check("R2 ctrl readback", {24'd0, v}, 32'h3);
    check("R2 seq_reset high", {31'd0, seq_reset}, 32'h1);
    host_write(2'd0, 8'h01);
    check("R2 seq_reset low", {31'd0, seq_reset}, 32'h0);
    host_read(2'd0, v); check("R2 load only", {24'd0, v}, 32'h1);
  endtask

  task automatic t_write_word;
    logic [8:0] a;
    int base;
    logic [7:0] bytes [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    set_addr(9'h005);
    base = we_cnt;
    for (int i = 0; i < 3; i++) begin
      host_write(2'd1, bytes[i]);
      read_addr(a); check("R4 addr held", {23'd0, a}, 32'h5);
    end
    host_write(2'd1, bytes[3]);
    check("R3 one commit", we_cnt, base + 1);
    check("R3 commit addr", {23'd0, last_waddr}, 32'h5);
    check("R3 commit data", last_wdata, 32'h44332211);
    read_addr(a); check("R4 addr advanced", {23'd0, a}, 32'h6);
  endtask

  task automatic t_high_addr;
    logic [7:0] v;
    host_write(2'd2, 8'h2A);
    host_write(2'd3, 8'hFF);
    host_read(2'd3, v); check("R5 hi upper zero", {24'd0, v}, 32'h1);
    host_write(2'd1, 8'hA0); host_write(2'd1, 8'hA1);
    host_write(2'd1, 8'hA2); host_write(2'd1, 8'hA3);
    check("R5 nine-bit addr", {23'd0, last_waddr}, 32'h12A);
    check("R5 data", last_wdata, 32'hA3A2A1A0);
  endtask

  task automatic t_idx_reset;
    set_addr(9'h010);
    host_write(2'd1, 8'h01); host_write(2'd1, 8'h02);
    host_write(2'd2, 8'h10);
    host_write(2'd1, 8'hAA); host_write(2'd1, 8'hBB);
    host_write(2'd1, 8'hCC); host_write(2'd1, 8'hDD);
    check("R6 restart addr", {23'd0, last_waddr}, 32'h10);
    check("R6 restart data", last_wdata, 32'hDDCCBBAA);
  endtask

  task automatic t_ignore;
    logic [8:0] a;
    int base;
    host_write(2'd0, 8'h00);
    set_addr(9'h020);
    base = we_cnt;
    for (int i = 0; i < 4; i++) host_write(2'd1, 8'h90 + 8'(i));
    check("R7 no commit when disabled", we_cnt, base);
    read_addr(a); check("R7 addr unchanged", {23'd0, a}, 32'h20);
    host_write(2'd0, 8'h01);
    host_write(2'd1, 8'h01); host_write(2'd1, 8'h02);
    host_write(2'd0, 8'h00);
    host_write(2'd1, 8'hEE); host_write(2'd1, 8'hEF);
    host_write(2'd0, 8'h01);
    host_write(2'd1, 8'h03); host_write(2'd1, 8'h04);
    check("R7 one commit", we_cnt, base + 1);
    check("R7 resumed word", last_wdata, 32'h04030201);
    check("R7 resumed addr", {23'd0, last_waddr}, 32'h20);
  endtask

  task automatic t_read;
    logic [7:0] v;
    logic [8:0] a;
    logic [7:0] exp [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    set_addr(9'h005);
    for (int i = 0; i < 4; i++) begin
      host_read(2'd1, v); check("R8 read byte", {24'd0, v}, {24'd0, exp[i]});
      read_addr(a);
      check("R8 read addr", {23'd0, a}, (i == 3) ? 32'h6 : 32'h5);
    end
  endtask

  task automatic t_wrap;
    logic [8:0] a;
    logic [7:0] v;
    set_addr(9'h1FF);
    host_write(2'd1, 8'h5A); host_write(2'd1, 8'h6B);
    host_write(2'd1, 8'h7C); host_write(2'd1, 8'h8D);
    check("R9 top addr", {23'd0, last_waddr}, 32'h1FF);
    read_addr(a); check("R9 wrap after write", {23'd0, a}, 32'h0);
    set_addr(9'h1FF);
    host_read(2'd1, v); check("R9 byte0", {24'd0, v}, 32'h5A);
    host_read(2'd1, v); host_read(2'd1, v);
    host_read(2'd1, v); check("R9 byte3", {24'd0, v}, 32'h8D);
    read_addr(a); check("R9 wrap after read", {23'd0, a}, 32'h0);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    reg_sel = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_write_word();
    t_high_addr();
    t_idx_reset();
    t_ignore();
    t_read();
    t_wrap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule